// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block chooses which interrupt request a small processor core services next. It takes one non-maskable input, a set of internal request lines and five external request pins. It offers the winning request to the core as a vector type, using a valid/ready handshake. Once the core has taken a vector, the block sets an in-service bit for that source. While that bit is set, the same source and every source of lower priority are held off. A source of higher priority can still interrupt the handler. Software ends a handler by writing the type of the source to the end-of-interrupt register. This clears the in-service bit and lets the held-off sources through again.

A small write-only register bus sets the per-source mask and two cascade bits. The cascade bits change the role of the external pins. When a pin is cascaded, an outside controller supplies the vector type on a shared type bus. The block tells that controller when its vector is taken by pulsing an acknowledge line. The pin that would carry that pair's acknowledge in hardware is then no longer a request. Internal sources behave the same in every mode.

The core interface is a stream with one slot. `irq_o` is valid and `ack_i` is ready. Once an offer is made, it is held and `vec_type_o` stays stable until the core raises `ack_i`. This holds even if the request drops or a higher request arrives in the meantime. The transfer happens on the cycle in which both are high. `ack_i` has no effect while `irq_o` is low.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset `irq_o` and `cas_ack_o` are low and every maskable source is masked, so raised requests produce no offer until the mask is written.
- R2: Priority is fixed. The non-maskable input comes first, then internal sources 0..NUM_INT-1, then pins 0..4, with lower numbers winning within each group. Internal types are 8'h02 for the non-maskable input, 8'h10+k for internal source k and 8'h20+i for pin i. A maskable request present before a clock edge is offered from that edge on.
- R3: A write to address 0 loads the mask: bit k masks internal source k, and bit NUM_INT+i masks pin i (1 = masked). A masked source is never offered.
- R4: While `irq_o` is high and `ack_i` is low, `irq_o` stays high and `vec_type_o` is unchanged, whatever happens on the request lines.
- R5: A handshake sets the in-service bit of the taken source. While it is set, that source is not offered again.
- R6: While a source is in service, sources of lower priority are not offered, and sources of higher priority still are.
- R7: A write to address 3 with data[7:0] equal to a source's internal type clears that source's in-service bit. On the next edge that source and the sources below it become eligible again.
- R8: A rising edge on `nmi_i` is offered with type 8'h02 from the second clock edge after it. The mask and in-service bits have no effect on it, and each rising edge gives exactly one offer.
- R9: Bit 0 of address 1 cascades pin 0, and the pin 2 request is then ignored. Bit 0 of address 2 cascades pin 1, and the pin 3 request is then ignored.
- R10: When a cascaded pin 0 (pin 1) is offered, `vec_type_o` follows `cas_type_i`, and `cas_ack_o[0]` (`cas_ack_o[1]`) is high during the handshake cycle only. It stays low for all other handshakes.
- R11: Pins that are not cascaded, and all internal sources, keep their internal types in every cascade setting. An end-of-interrupt for a cascaded pin uses that pin's internal type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, edge triggered |
| int_req_i | input | NUM_INT | Internal request levels |
| ext_req_i | input | 5 | External request pins 0..4 (level) |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 mask, 1 cascade pin 0, 2 cascade pin 1, 3 end of interrupt) |
| bus_wdata | input | DW | Write data (DW = max(NUM_INT+5, 8)) |
| cas_type_i | input | 8 | Vector type supplied by an external cascaded controller |
| ack_i | input | 1 | Core ready: takes the offered vector |
| irq_o | output | 1 | Offer valid |
| vec_type_o | output | 8 | Offered vector type |
| cas_ack_o | output | 2 | Per-pair acknowledge pulse for cascaded pins 0 and 1 |

## Verification
A table of cases tries the arbitration with single requests, with every line raised at once, with pins masked, with all sources masked, and with each cascade setting. Together these show whether internal sources beat pins, whether the mask is honoured, whether cascading reroutes the type and the acknowledge pulse, and whether the ignored pins stay quiet. Directed sequences then stack in-service bits in both orders. These separate blocking by the source itself from blocking by a higher source, and check that a higher source can still pre-empt. They also hold an offer against changing requests, and step the non-maskable input to show it fires once per edge even with everything masked.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NUM_PINS = 5;
  localparam logic [7:0] TYPE_NMI = 8'h02;
  localparam logic [7:0] TYPE_INT_BASE = 8'h10;
  localparam logic [7:0] TYPE_PIN_BASE = 8'h20;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_CASC0 = 2'd1;
  localparam logic [1:0] ADDR_CASC1 = 2'd2;
  localparam logic [1:0] ADDR_EOI = 2'd3;

  // Internal vector type of source slot idx (internal sources first, then pins).
  function automatic logic [7:0] src_type(input int unsigned idx, input int unsigned nint);
    if (idx < nint) return TYPE_INT_BASE + 8'(idx);
    return TYPE_PIN_BASE + 8'(idx - nint);
  endfunction
endpackage

// File: rtl/nic_regs.sv
module nic_regs #(
  parameter int NSRC = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [NSRC-1:0] mask,
  output logic [1:0]      casc,
  output logic            eoi_v,
  output logic [7:0]      eoi_type
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
      casc <= '0;
    end else if (wr_en) begin
      case (addr)
        nic_pkg::ADDR_MASK:  mask <= wdata[NSRC-1:0];
        nic_pkg::ADDR_CASC0: casc[0] <= wdata[0];
        nic_pkg::ADDR_CASC1: casc[1] <= wdata[0];
        default: ;
      endcase
    end
  end

  // End-of-interrupt acts in the write cycle itself.
  assign eoi_v = wr_en && (addr == nic_pkg::ADDR_EOI);
  assign eoi_type = wdata[7:0];
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int NSRC = 8,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] is_q,
  output logic            win_v,
  output logic [IW-1:0]   win_idx
);
  logic [NSRC-1:0] elig;

  // A slot is blocked by any in-service bit at its own or a higher priority.
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      acc = acc | is_q[s];
      elig[s] = req[s] & ~acc;
    end
  end

  always_comb begin
    win_v = 1'b0;
    win_idx = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (elig[s]) begin
        win_v = 1'b1;
        win_idx = IW'(s);
      end
    end
  end

  // R6: the winner never sits under an active in-service bit of its own
  p_win_not_in_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_v |-> (is_q[win_idx] == 1'b0));
  // R3: a winner always has a live effective request
  p_win_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_v |-> req[win_idx]);
endmodule

// File: rtl/nic_inservice.sv
module nic_inservice #(
  parameter int NSRC = 8,
  parameter int NUM_INT = 3,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_v,
  input  logic [IW-1:0]   set_idx,
  input  logic            eoi_v,
  input  logic [7:0]      eoi_type,
  output logic [NSRC-1:0] is_q
);
  for (genvar s = 0; s < NSRC; s++) begin : g_bit
    localparam logic [7:0] SRC_TY = nic_pkg::src_type(s, NUM_INT);
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else if (set_v && (set_idx == IW'(s))) bit_q <= 1'b1;
      else if (eoi_v && (eoi_type == SRC_TY)) bit_q <= 1'b0;
    end
    assign is_q[s] = bit_q;
  end

  // R5: at most one in-service bit is raised per cycle
  p_one_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(is_q & ~$past(is_q)) <= 1));
  // R7: in-service bits fall only after an end-of-interrupt write
  p_clear_by_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(is_q) & ~is_q) == '0) || $past(eoi_v)));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NUM_INT = 3,
  localparam int NSRC = NUM_INT + nic_pkg::NUM_PINS,
  localparam int IW = $clog2(NSRC),
  localparam int DW = (NSRC > 8) ? NSRC : 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          nmi_i,
  input  logic [NUM_INT-1:0]            int_req_i,
  input  logic [nic_pkg::NUM_PINS-1:0]  ext_req_i,
  input  logic                          bus_wr_en,
  input  logic [1:0]                    bus_addr,
  input  logic [DW-1:0]                 bus_wdata,
  input  logic [7:0]                    cas_type_i,
  input  logic                          ack_i,
  output logic                          irq_o,
  output logic [7:0]                    vec_type_o,
  output logic [1:0]                    cas_ack_o
);
  logic [NSRC-1:0] mask, is_q, req_eff;
  logic [1:0] casc;
  logic eoi_v;
  logic [7:0] eoi_type;
  logic [nic_pkg::NUM_PINS-1:0] pin_live;
  logic win_v;
  logic [IW-1:0] win_idx;

  logic offer_v, offer_nmi;
  logic [IW-1:0] offer_idx;
  logic nmi_q, nmi_pend;
  logic take, cas_sel0, cas_sel1;

  nic_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .mask(mask), .casc(casc), .eoi_v(eoi_v), .eoi_type(eoi_type)
  );

  // Cascaded pairs take over pins 2 and 3 as their acknowledge positions.
  always_comb begin
    pin_live = ext_req_i;
    if (casc[0]) pin_live[2] = 1'b0;
    if (casc[1]) pin_live[3] = 1'b0;
  end
  assign req_eff = {pin_live, int_req_i} & ~mask;

  nic_arbiter #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_eff), .is_q(is_q), .win_v(win_v), .win_idx(win_idx)
  );

  assign take = offer_v && ack_i;

  nic_inservice #(.NSRC(NSRC), .NUM_INT(NUM_INT)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_v(take && !offer_nmi), .set_idx(offer_idx),
    .eoi_v(eoi_v), .eoi_type(eoi_type), .is_q(is_q)
  );

  // Non-maskable edge capture: one pending offer per rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      nmi_pend <= (nmi_pend && !(take && offer_nmi)) || (nmi_i && !nmi_q);
    end
  end

  // Single offer slot toward the core (valid = irq_o, ready = ack_i).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_v <= 1'b0;
      offer_nmi <= 1'b0;
      offer_idx <= '0;
    end else if (take) begin
      offer_v <= 1'b0;
      offer_nmi <= 1'b0;
    end else if (!offer_v) begin
      if (nmi_pend) begin
        offer_v <= 1'b1;
        offer_nmi <= 1'b1;
      end else if (win_v) begin
        offer_v <= 1'b1;
        offer_idx <= win_idx;
      end
    end
  end

  assign cas_sel0 = offer_v && !offer_nmi && (offer_idx == IW'(NUM_INT)) && casc[0];
  assign cas_sel1 = offer_v && !offer_nmi && (offer_idx == IW'(NUM_INT + 1)) && casc[1];

  assign irq_o = offer_v;
  always_comb begin
    if (offer_nmi) vec_type_o = nic_pkg::TYPE_NMI;
    else if (cas_sel0 || cas_sel1) vec_type_o = cas_type_i;
    else vec_type_o = nic_pkg::src_type(32'(offer_idx), NUM_INT);
  end
  assign cas_ack_o = {cas_sel1 && take, cas_sel0 && take};

  // R4: an untaken internal-type offer holds steady
  p_hold_offer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i && !cas_sel0 && !cas_sel1) |=> (irq_o && $stable(vec_type_o)));
  // R10: pair acknowledges are exclusive and only in a handshake
  p_cas_ack_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cas_ack_o));
  p_cas_ack_handshake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_ack_o != 2'b00) |-> (irq_o && ack_i));
  // R8: a pending non-maskable edge is offered once the slot frees
  p_nmi_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !offer_v) |=> (irq_o && vec_type_o == nic_pkg::TYPE_NMI));
endmodule

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_i = 1'b0;
  logic [2:0] int_req_i = '0;
  logic [4:0] ext_req_i = '0;
  logic bus_wr_en = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] cas_type_i = '0;
  logic ack_i = 1'b0;
  logic irq_o;
  logic [7:0] vec_type_o;
  logic [1:0] cas_ack_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nest_irq_ctrl #(.NUM_INT(3)) uut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .int_req_i(int_req_i), .ext_req_i(ext_req_i),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cas_type_i(cas_type_i),
    .ack_i(ack_i), .irq_o(irq_o), .vec_type_o(vec_type_o), .cas_ack_o(cas_ack_o)
  );

  typedef struct packed {
    logic [7:0] mask;
    logic [1:0] casc;
    logic [4:0] ext;
    logic [2:0] intr;
    logic [7:0] ctype;
    logic       eirq;
    logic [7:0] etype;
    logic [1:0] ecack;
    logic [7:0] eoi;
  } vec_t;

  // mask bits [2:0] internal, [7:3] pins 0..4
  localparam vec_t VECS [10] = '{
    '{8'h00, 2'd0, 5'b10100, 3'b000, 8'h00, 1'b1, 8'h22, 2'd0, 8'h22}, // R2 pin2 over pin4
    '{8'h00, 2'd0, 5'b11111, 3'b100, 8'h00, 1'b1, 8'h12, 2'd0, 8'h12}, // R2 internal over pins
    '{8'h00, 2'd0, 5'b00000, 3'b011, 8'h00, 1'b1, 8'h10, 2'd0, 8'h10}, // R2 internal order
    '{8'h08, 2'd0, 5'b00011, 3'b000, 8'h00, 1'b1, 8'h21, 2'd0, 8'h21}, // R3 pin0 masked
    '{8'hFF, 2'd0, 5'b11111, 3'b111, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00}, // R3 all masked
    '{8'h00, 2'd1, 5'b00100, 3'b000, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00}, // R9 pin2 ignored
    '{8'h00, 2'd1, 5'b00001, 3'b000, 8'h5A, 1'b1, 8'h5A, 2'd1, 8'h20}, // R10 pair 0
    '{8'h00, 2'd3, 5'b01110, 3'b000, 8'h77, 1'b1, 8'h77, 2'd2, 8'h21}, // R10 pair 1, pin3 ignored
    '{8'h00, 2'd3, 5'b10000, 3'b000, 8'h00, 1'b1, 8'h24, 2'd0, 8'h24}, // R11 pin4 direct
    '{8'h00, 2'd1, 5'b01000, 3'b000, 8'h00, 1'b1, 8'h23, 2'd0, 8'h23}  // R11 pin3 direct in mode one
  };

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic take_it();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    ext_req_i = '0;
    int_req_i = '0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_o == 1'b0, "R1 irq after reset", 16'(irq_o), 16'h0);
    chk(cas_ack_o == 2'b00, "R1 cas_ack after reset", 16'(cas_ack_o), 16'h0);
    int_req_i = 3'b111;
    ext_req_i = 5'b11111;
    repeat (2) @(negedge clk);
    chk(irq_o == 1'b0, "R1 masked at reset", 16'(irq_o), 16'h0);
    int_req_i = '0;
    ext_req_i = '0;

    // Table walk
    for (int i = 0; i < 10; i++) begin
      wr(2'd0, VECS[i].mask);
      wr(2'd1, {7'b0, VECS[i].casc[0]});
      wr(2'd2, {7'b0, VECS[i].casc[1]});
      ext_req_i = VECS[i].ext;
      int_req_i = VECS[i].intr;
      cas_type_i = VECS[i].ctype;
      @(negedge clk);
      chk(irq_o == VECS[i].eirq, $sformatf("R2 R3 R9 vector %0d irq", i), 16'(irq_o), 16'(VECS[i].eirq));
      if (VECS[i].eirq) begin
        chk(vec_type_o == VECS[i].etype, $sformatf("R2 R11 vector %0d type", i),
            16'(vec_type_o), 16'(VECS[i].etype));
        ack_i = 1'b1;
        #1;
        chk(cas_ack_o == VECS[i].ecack, $sformatf("R10 vector %0d cas_ack", i),
            16'(cas_ack_o), 16'(VECS[i].ecack));
        @(negedge clk);
        ack_i = 1'b0;
        ext_req_i = '0;
        int_req_i = '0;
        wr(2'd3, VECS[i].eoi);
      end else begin
        @(negedge clk);
        chk(irq_o == 1'b0, $sformatf("R3 R9 vector %0d stays idle", i), 16'(irq_o), 16'h0);
        ext_req_i = '0;
        int_req_i = '0;
      end
    end

    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);

    // R4 hold against a new higher request
    ext_req_i = 5'b10000;
    @(negedge clk);
    chk(irq_o && vec_type_o == 8'h24, "R4 offer pin4", 16'(vec_type_o), 16'h24);
    int_req_i = 3'b001;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(irq_o && vec_type_o == 8'h24, "R4 held while not ready", 16'(vec_type_o), 16'h24);
    end
    take_it();

    // R5 same source blocked
    ext_req_i = 5'b10000;
    repeat (2) @(negedge clk);
    chk(irq_o == 1'b0, "R5 same source blocked", 16'(irq_o), 16'h0);

    // R6 higher pre-empts
    ext_req_i = 5'b11000;
    @(negedge clk);
    chk(irq_o && vec_type_o == 8'h23, "R6 higher pre-empts", 16'(vec_type_o), 16'h23);
    take_it();

    // R7 end of interrupt
    wr(2'd3, 8'h23);
    ext_req_i = 5'b10000;
    repeat (2) @(negedge clk);
    chk(irq_o == 1'b0, "R7 other eoi leaves pin4 blocked", 16'(irq_o), 16'h0);
    wr(2'd3, 8'h24);
    @(negedge clk);
    chk(irq_o && vec_type_o == 8'h24, "R7 eoi re-enables", 16'(vec_type_o), 16'h24);
    take_it();
    wr(2'd3, 8'h24);

    // R6 lower blocked, R7 releases it
    ext_req_i = 5'b00010;
    @(negedge clk);
    chk(irq_o && vec_type_o == 8'h21, "R6 offer pin1", 16'(vec_type_o), 16'h21);
    take_it();
    ext_req_i = 5'b00100;
    repeat (2) @(negedge clk);
    chk(irq_o == 1'b0, "R6 lower blocked", 16'(irq_o), 16'h0);
    wr(2'd3, 8'h21);
    @(negedge clk);
    chk(irq_o && vec_type_o == 8'h22, "R7 lower released", 16'(vec_type_o), 16'h22);
    take_it();
    wr(2'd3, 8'h22);

    // R8 non-maskable edge
    wr(2'd0, 8'hFF);
    nmi_i = 1'b1;
    @(negedge clk);
    chk(irq_o == 1'b0, "R8 not yet offered", 16'(irq_o), 16'h0);
    @(negedge clk);
    chk(irq_o && vec_type_o == 8'h02, "R8 nmi offered while masked", 16'(vec_type_o), 16'h02);
    take_it();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(irq_o == 1'b0, "R8 one offer per edge", 16'(irq_o), 16'h0);
    end
    nmi_i = 1'b0;
    @(negedge clk);
    nmi_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq_o && vec_type_o == 8'h02, "R8 second edge offered", 16'(vec_type_o), 16'h02);
    take_it();
    nmi_i = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule